// File: doc/BRIEF.md
# External Interrupt Trap Entry Unit

This unit works next to a simple in-order 32-bit core. It accepts a request line from an external interrupt source, which may be a level or a single-cycle pulse, and holds the request in an internal flag. At each instruction the core retires, the unit works out the address the core would fetch next. It then decides whether to send the core to the trap handler instead.

The next address is the retired instruction's own address plus 2 for a 16-bit encoding, or plus 4 for a 32-bit one. When the instruction changed control flow, the next address is the target the core reports instead. A trap is entered only on a retirement where the flag is set and the external-pending bit of the pending register (bit 11) is clear. On that boundary the unit sets the pending bit, saves the next address as the return address and records the cause. In the same cycle it raises a redirect strobe carrying the trap base address with its two low bits cleared.

On a retirement with no flag set, the pending bit is dropped again. The pending, return-address, cause and trap-base registers can be read and written through a small register port.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset the pending (0x344), return-address (0x341), cause (0x342) and trap-base (0x305) registers all read 0, the request flag is clear and `trap_redirect` is low.
- R2: A cycle with `ext_irq` high sets the request flag. The flag stays set across any number of cycles without a retirement, and is cleared only by a retirement that enters the trap.
- R3: On a retirement where the flag is set and pending bit 11 is 0, `trap_redirect` is high in that same cycle and pending bit 11 reads 1 from the next cycle.
- R4: On a trap entry the return-address register receives the next address. This is `ret_jump_pc` when `ret_jump` is 1. Otherwise it is `ret_pc + 2` when `ret_short` is 1 and `ret_pc + 4` when `ret_short` is 0.
- R5: While `trap_redirect` is high, `trap_pc` equals the trap-base register with bits [1:0] forced to 0.
- R6: On a trap entry the cause register becomes 0x8000000B: bit 31 set for an interrupt and code 11 for the machine external source.
- R7: On a retirement where the flag is set and pending bit 11 is already 1, no redirect occurs and the flag stays set.
- R8: On a retirement where the flag is clear, pending bit 11 is cleared.
- R9: `trap_redirect` is high only in a cycle with `ret_valid` high, and lasts one cycle per trap entry.
- R10: The register port reads the four registers at their addresses, and any other address reads 0. Writes store all 32 bits, except that the port has no effect on pending bit 11.
- R11: When a port write to the return-address or cause register falls in the same cycle as a trap entry, the trap entry's value is the one kept.
- R12: The trap decision uses only the flag as it stood before the cycle. A request arriving in the same cycle as a retirement is seen at the next retirement. A request arriving in the same cycle as a trap entry leaves the flag set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | 1 | External interrupt request, level or pulse |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_pc | input | 32 | Address of the retiring instruction |
| ret_short | input | 1 | Retiring instruction is a 16-bit encoding |
| ret_jump | input | 1 | Retiring instruction changed control flow |
| ret_jump_pc | input | 32 | Control-flow target when `ret_jump` is 1 |
| csr_we | input | 1 | Register port write enable |
| csr_addr | input | 12 | Register port address |
| csr_wdata | input | 32 | Register port write data |
| csr_rdata | output | 32 | Register port read data (combinational) |
| trap_redirect | output | 1 | Redirect the core to the trap handler |
| trap_pc | output | 32 | Redirect target, valid while `trap_redirect` is high |

## Verification
A stale or wrongly cleared request flag appears at the ports at the next retirement. It shows either as a missing `trap_redirect` or as a redirect where none is due. A wrong pending bit shows the same way, because the bit gates the trap decision, and it also shows on the very next read of address 0x344. Errors in the next-address arithmetic or the cause value show on the first read of 0x341 or 0x342 after a trap entry. The bench reads these registers in the cycles right after each entry, so such errors appear within one cycle.

// File: rtl/irq_entry_unit.sv
module irq_entry_unit #(
  parameter int          XLEN       = 32,
  parameter int          AW         = 12,
  parameter int          EXT_BIT    = 11,
  parameter logic [11:0] ADDR_PEND  = 12'h344,
  parameter logic [11:0] ADDR_EPC   = 12'h341,
  parameter logic [11:0] ADDR_CAUSE = 12'h342,
  parameter logic [11:0] ADDR_TBASE = 12'h305
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_irq,
  input  logic            ret_valid,
  input  logic [XLEN-1:0] ret_pc,
  input  logic            ret_short,
  input  logic            ret_jump,
  input  logic [XLEN-1:0] ret_jump_pc,
  input  logic            csr_we,
  input  logic [AW-1:0]   csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            trap_redirect,
  output logic [XLEN-1:0] trap_pc
);
  localparam logic [XLEN-1:0] EXT_MASK  = XLEN'(1) << EXT_BIT;
  localparam logic [XLEN-1:0] CAUSE_VAL = (XLEN'(1) << (XLEN-1)) | XLEN'(EXT_BIT);

  logic            req_q;
  logic [XLEN-1:0] pend_q, epc_q, cause_q, tbase_q;
  logic [XLEN-1:0] next_pc;
  logic            take;

  assign next_pc       = ret_jump ? ret_jump_pc : ret_pc + (ret_short ? XLEN'(2) : XLEN'(4));
  assign take          = ret_valid && req_q && !pend_q[EXT_BIT];
  assign trap_redirect = take;
  assign trap_pc       = take ? {tbase_q[XLEN-1:2], 2'b00} : '0;

  always_comb begin
    case (csr_addr)
      ADDR_PEND:  csr_rdata = pend_q;
      ADDR_EPC:   csr_rdata = epc_q;
      ADDR_CAUSE: csr_rdata = cause_q;
      ADDR_TBASE: csr_rdata = tbase_q;
      default:    csr_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      pend_q  <= '0;
      epc_q   <= '0;
      cause_q <= '0;
      tbase_q <= '0;
    end else begin
      req_q <= ext_irq || (req_q && !take);

      if (csr_we && csr_addr == ADDR_PEND)
        pend_q <= (csr_wdata & ~EXT_MASK) | (pend_q & EXT_MASK);
      if (ret_valid) begin
        if (take)        pend_q[EXT_BIT] <= 1'b1;
        else if (!req_q) pend_q[EXT_BIT] <= 1'b0;
      end

      if (take)                              epc_q <= next_pc;
      else if (csr_we && csr_addr == ADDR_EPC) epc_q <= csr_wdata;

      if (take)                                cause_q <= CAUSE_VAL;
      else if (csr_we && csr_addr == ADDR_CAUSE) cause_q <= csr_wdata;

      if (csr_we && csr_addr == ADDR_TBASE) tbase_q <= csr_wdata;
    end
  end
endmodule

module irq_entry_unit_chk #(
  parameter int XLEN    = 32,
  parameter int EXT_BIT = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ret_valid,
  input logic            trap_redirect,
  input logic [XLEN-1:0] trap_pc,
  input logic            req_q,
  input logic [XLEN-1:0] pend_q,
  input logic [XLEN-1:0] cause_q
);
  a_r9_redirect_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
    trap_redirect |-> ret_valid);
  a_r3_pending_set_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    trap_redirect |=> pend_q[EXT_BIT]);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trap_redirect |=> !trap_redirect);
  a_r6_cause_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    trap_redirect |=> cause_q == ((XLEN'(1) << (XLEN-1)) | XLEN'(EXT_BIT)));
  a_r5_target_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    trap_redirect |-> trap_pc[1:0] == 2'b00);
  a_r8_pending_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !req_q) |=> !pend_q[EXT_BIT]);
  a_r7_flag_kept_while_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && pend_q[EXT_BIT]) |=> req_q);
endmodule

bind irq_entry_unit irq_entry_unit_chk #(.XLEN(XLEN), .EXT_BIT(EXT_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .trap_redirect(trap_redirect),
  .trap_pc(trap_pc), .req_q(req_q), .pend_q(pend_q), .cause_q(cause_q)
);

// File: tb/tb_irq_entry_unit.sv
module tb_irq_entry_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_PEND = 12'h344, A_EPC = 12'h341, A_CAUSE = 12'h342, A_TBASE = 12'h305;

  logic clk = 0, rst_n = 0;
  logic ext_irq = 0, ret_valid = 0, ret_short = 0, ret_jump = 0, csr_we = 0;
  logic [31:0] ret_pc = 0, ret_jump_pc = 0, csr_wdata = 0;
  logic [11:0] csr_addr = 0;
  logic [31:0] csr_rdata, trap_pc;
  logic trap_redirect;

  int checks = 0, fails = 0;
  bit m_flag;
  logic [31:0] m_pend, m_epc, m_cause, m_tbase;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_unit dut (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_short(ret_short), .ret_jump(ret_jump), .ret_jump_pc(ret_jump_pc),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .trap_redirect(trap_redirect), .trap_pc(trap_pc)
  );

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      A_PEND:  return m_pend;
      A_EPC:   return m_epc;
      A_CAUSE: return m_cause;
      A_TBASE: return m_tbase;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(logic [11:0] a);
    case (a)
      A_PEND:  return "R8/R10";
      A_EPC:   return "R4/R11";
      A_CAUSE: return "R6/R11";
      A_TBASE: return "R10";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ext_irq = 0; ret_valid = 0; csr_we = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_flag = 0; m_pend = 0; m_epc = 0; m_cause = 0; m_tbase = 0;
  endtask

  task automatic step(bit irq, bit ret, bit sh, bit jmp, logic [31:0] pc, logic [31:0] jpc,
                      bit we, logic [11:0] addr, logic [31:0] wd);
    bit take, nflag;
    logic [31:0] npc, np, ne, nc, nt;
    @(negedge clk);
    ext_irq = irq; ret_valid = ret; ret_short = sh; ret_jump = jmp;
    ret_pc = pc; ret_jump_pc = jpc; csr_we = we; csr_addr = addr; csr_wdata = wd;
    #1;
    take = ret && m_flag && !m_pend[11];
    npc  = jmp ? jpc : pc + (sh ? 32'd2 : 32'd4);
    check("R3/R7/R9 redirect", {31'b0, trap_redirect}, {31'b0, take});
    if (take) check("R5 target", trap_pc, {m_tbase[31:2], 2'b00});
    check(req_of(addr), csr_rdata, model_read(addr));
    nflag = irq || (m_flag && !take);
    np = m_pend; ne = m_epc; nc = m_cause; nt = m_tbase;
    if (we && addr == A_PEND)  np = (wd & ~32'h800) | (m_pend & 32'h800);
    if (we && addr == A_EPC)   ne = wd;
    if (we && addr == A_CAUSE) nc = wd;
    if (we && addr == A_TBASE) nt = wd;
    if (ret) begin
      if (take) np[11] = 1'b1;
      else if (!m_flag) np[11] = 1'b0;
    end
    if (take) begin ne = npc; nc = 32'h8000000B; end
    @(posedge clk);
    m_flag = nflag; m_pend = np; m_epc = ne; m_cause = nc; m_tbase = nt;
  endtask

  task automatic rd(logic [11:0] a);
    step(0, 0, 0, 0, 0, 0, 0, a, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    do_reset();
    // R1: reset state
    @(negedge clk); csr_addr = A_PEND;  #1; check("R1 pend",  csr_rdata, 0);
    csr_addr = A_EPC;   #1; check("R1 epc",   csr_rdata, 0);
    csr_addr = A_CAUSE; #1; check("R1 cause", csr_rdata, 0);
    csr_addr = A_TBASE; #1; check("R1 tbase", csr_rdata, 0);
    check("R1 redirect", {31'b0, trap_redirect}, 0);

    // R10: base write with low bits, pending write cannot touch bit 11, unmapped reads 0
    step(0, 0, 0, 0, 0, 0, 1, A_TBASE, 32'h0000_1003);
    step(0, 0, 0, 0, 0, 0, 1, A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND); rd(12'h300);
    step(0, 0, 0, 0, 0, 0, 1, A_PEND, 32'h0);

    // R2: pulse held across idle cycles; R3/R4/R5/R6: entry after a 32-bit instruction
    step(1, 0, 0, 0, 0, 0, 0, A_PEND, 0);
    rd(A_PEND); rd(A_PEND);
    step(0, 1, 0, 0, 32'h100, 0, 0, A_PEND, 0);
    rd(A_PEND); rd(A_EPC); rd(A_CAUSE);
    // R8: retirement without flag drops bit 11
    step(0, 1, 0, 0, 32'h104, 0, 0, A_PEND, 0);
    rd(A_PEND);

    // R4: 16-bit step, and R11: port write loses to entry
    step(1, 0, 0, 0, 0, 0, 0, A_PEND, 0);
    step(0, 1, 1, 0, 32'h200, 0, 1, A_EPC, 32'hDEAD_BEEF);
    rd(A_EPC);
    step(0, 1, 0, 0, 32'h202, 0, 0, A_PEND, 0);
    // R4: control-flow target
    step(1, 0, 0, 0, 0, 0, 0, A_PEND, 0);
    step(0, 1, 1, 1, 32'h300, 32'h3000, 1, A_CAUSE, 32'h1234);
    rd(A_EPC); rd(A_CAUSE);
    step(0, 1, 0, 0, 32'h3000, 0, 0, A_PEND, 0);

    // R12: request in retirement cycle is seen only at the next one
    step(1, 1, 0, 0, 32'h400, 0, 0, A_PEND, 0);
    step(0, 1, 0, 0, 32'h404, 0, 0, A_EPC, 0);
    rd(A_EPC);
    // R12 + R7: request during entry re-latches, next retirement blocked
    step(1, 1, 0, 0, 32'h500, 0, 0, A_PEND, 0);
    step(1, 1, 0, 0, 32'h600, 0, 0, A_PEND, 0);
    step(0, 1, 0, 0, 32'h604, 0, 0, A_PEND, 0);
    step(0, 1, 0, 0, 32'h608, 0, 0, A_EPC, 0);

    // random mix against the model, periodic reset
    for (int i = 0; i < 3000; i++) begin
      if (i % 60 == 0) do_reset();
      step(($urandom % 8) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0, ($urandom % 4) == 0,
           $urandom & 32'hFFFF_FFFE, $urandom & 32'hFFFF_FFFE, ($urandom % 4) == 0,
           ($urandom % 5 == 0) ? A_PEND : ($urandom % 5 == 1) ? A_EPC :
           ($urandom % 5 == 2) ? A_CAUSE : ($urandom % 5 == 3) ? A_TBASE : 12'h300,
           $urandom);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule